// File: doc/BRIEF.md
# Binary/BCD Add-Subtract Unit

This block is the arithmetic core of an 8-bit accumulator datapath. It adds two operands with a carry-in, or subtracts one from the other with a borrow taken from the carry-in. A mode input selects plain binary arithmetic or packed decimal arithmetic, where each 4-bit nibble holds one decimal digit. In decimal mode the digit correction happens inside the unit, so no separate adjust step is needed after the operation.

The unit is purely combinational. It drives a carry-out for the surrounding status register, together with negative, overflow and zero flag values. Two write enables tell the status register which of these outputs to load. The carry enable follows the operation strobe. The enable for the other three flags is suppressed in decimal mode, because those flags carry no meaning there. The number of digits is a parameter, and the default is two digits (8 bits).

Top module: `bcd_addsub`

## Requirements
- R1: With decimal mode 0 and add selected, `{cout_o,res_o}` equals a + b + cin as an unsigned 9-bit value.
- R2: With decimal mode 0 and subtract selected, `res_o` equals (a − b − (1 − cin)) mod 256. `cout_o` is 1 exactly when no borrow occurred (a ≥ b + 1 − cin). A carry-in of 1 means no borrow is pending.
- R3: In binary mode, `v_o` is 1 exactly when the two's-complement result of the add or subtract falls outside −128..127.
- R4: In binary mode, `n_o` equals bit 7 of `res_o` and `z_o` is 1 exactly when `res_o` is zero.
- R5: With decimal mode 1, add selected and both operands valid packed BCD, `res_o` is the packed BCD of (A + B + cin) mod 100 and `cout_o` is 1 exactly when A + B + cin ≥ 100.
- R6: With decimal mode 1, subtract selected and BCD operands, `res_o` is the packed BCD of (A − B − (1 − cin)) mod 100 and `cout_o` is 0 exactly when that difference is negative.
- R7: In decimal mode with `op_valid_i` high, `carry_we_o` is 1 and `nvz_we_o` is 0.
- R8: In binary mode with `op_valid_i` high, both `carry_we_o` and `nvz_we_o` are 1.
- R9: With `op_valid_i` low, both write enables are 0 in either mode.
- R10: Decimal addition corrects each nibble on its own. A digit sum above 9 has 6 added to it, keeps the low 4 bits, and passes a carry to the next digit or to `cout_o`. So 0x0A+0x00 gives 0x10, 0x0F+0x0F gives 0x14, and 0xA0+0x00 gives 0x00 with carry 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_valid_i | input | 1 | Operation strobe; gates the flag write enables |
| sub_i | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_i | input | 1 | 0 = binary, 1 = packed decimal |
| cin_i | input | 1 | Carry-in (for subtract, 1 = no borrow) |
| a_i | input | 8 | First operand (minuend for subtract) |
| b_i | input | 8 | Second operand (subtrahend for subtract) |
| res_o | output | 8 | Result |
| cout_o | output | 1 | Carry-out (for subtract, 1 = no borrow) |
| carry_we_o | output | 1 | Load enable for the carry flag |
| n_o | output | 1 | Negative flag value |
| v_o | output | 1 | Signed overflow flag value |
| z_o | output | 1 | Zero flag value |
| nvz_we_o | output | 1 | Load enable for N, V and Z |

## Verification
Binary mode is run exhaustively over every operand pair, both carry-ins and both operations. This separates the carry and borrow conventions and the signed-overflow cases from plain wraparound. Decimal mode is run over all 100×100 BCD operand pairs with both carry-ins and both operations against integer arithmetic modulo 100. This separates correct per-digit correction and inter-digit carry from plain binary results. A short vector table covers wrap points (99+99+1, 00−01), equal operands with and without a pending borrow, and non-decimal nibbles that show the per-digit correction rule. Directed steps then show that the flag enables drop when the strobe is low.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;

  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned DEC_MAX = 9;
  localparam logic [DIGIT_W-1:0] DEC_ADJ = 4'd6;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
  } nvz_t;

  // raw digit sum above the largest decimal digit
  function automatic logic dec_over(input logic [DIGIT_W:0] s);
    return (s > (DIGIT_W+1)'(DEC_MAX));
  endfunction

endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_addsub_pkg::*;
(
  input  logic               sub_i,
  input  logic               dec_i,
  input  logic               cin_i,
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  output logic [DIGIT_W-1:0] digit_o,
  output logic               cout_o
);

  logic [DIGIT_W-1:0] b_eff;
  logic [DIGIT_W:0]   raw;
  logic               add_fix;

  // subtraction is a + ~b + cin, so one adder serves both operations
  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    raw     = {1'b0, a_i} + {1'b0, b_eff} + {{DIGIT_W{1'b0}}, cin_i};
    add_fix = dec_over(raw);
  end

  always_comb begin
    digit_o = raw[DIGIT_W-1:0];
    cout_o  = raw[DIGIT_W];
    if (dec_i) begin
      if (!sub_i) begin
        // decimal add: push digit past ten by adding six
        digit_o = raw[DIGIT_W-1:0] + (add_fix ? DEC_ADJ : '0);
        cout_o  = add_fix;
      end else if (!raw[DIGIT_W]) begin
        // decimal subtract with borrow out of this digit
        digit_o = raw[DIGIT_W-1:0] - DEC_ADJ;
      end
    end
  end

endmodule

// File: rtl/bcd_flag_unit.sv
module bcd_flag_unit
  import bcd_addsub_pkg::*;
#(
  parameter int unsigned WIDTH = 8
)(
  input  logic             op_valid_i,
  input  logic             dec_i,
  input  logic             a_msb_i,
  input  logic             b_eff_msb_i,
  input  logic [WIDTH-1:0] res_i,
  output nvz_t             flags_o,
  output logic             carry_we_o,
  output logic             nvz_we_o
);

  always_comb begin
    flags_o.n = res_i[WIDTH-1];
    flags_o.z = (res_i == '0);
    // overflow: like-signed inputs give an unlike-signed result
    flags_o.v = (a_msb_i == b_eff_msb_i) && (res_i[WIDTH-1] != a_msb_i);
  end

  always_comb begin
    carry_we_o = op_valid_i;
    nvz_we_o   = op_valid_i && !dec_i;
  end

endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_addsub_pkg::*;
#(
  parameter int unsigned NDIGITS = 2,
  localparam int unsigned WIDTH = NDIGITS * DIGIT_W
)(
  input  logic             op_valid_i,
  input  logic             sub_i,
  input  logic             dec_i,
  input  logic             cin_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o,
  output logic             carry_we_o,
  output logic             n_o,
  output logic             v_o,
  output logic             z_o,
  output logic             nvz_we_o
);

  logic [NDIGITS:0] carry_chain;
  logic [WIDTH-1:0] res_w;
  nvz_t             flags_w;

  assign carry_chain[0] = cin_i;

  for (genvar d = 0; d < NDIGITS; d++) begin : g_digit
    bcd_digit_stage u_stage (
      .sub_i   (sub_i),
      .dec_i   (dec_i),
      .cin_i   (carry_chain[d]),
      .a_i     (a_i[d*DIGIT_W +: DIGIT_W]),
      .b_i     (b_i[d*DIGIT_W +: DIGIT_W]),
      .digit_o (res_w[d*DIGIT_W +: DIGIT_W]),
      .cout_o  (carry_chain[d+1])
    );
  end

  bcd_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .op_valid_i  (op_valid_i),
    .dec_i       (dec_i),
    .a_msb_i     (a_i[WIDTH-1]),
    .b_eff_msb_i (b_i[WIDTH-1] ^ sub_i),
    .res_i       (res_w),
    .flags_o     (flags_w),
    .carry_we_o  (carry_we_o),
    .nvz_we_o    (nvz_we_o)
  );

  assign res_o  = res_w;
  assign cout_o = carry_chain[NDIGITS];
  assign n_o    = flags_w.n;
  assign v_o    = flags_w.v;
  assign z_o    = flags_w.z;

endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
  parameter int unsigned NDIGITS = 2,
  localparam int unsigned WIDTH = NDIGITS * 4
)(
  input logic             op_valid_i,
  input logic             sub_i,
  input logic             dec_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] res_o,
  input logic             cout_o,
  input logic             carry_we_o,
  input logic             n_o,
  input logic             v_o,
  input logic             z_o,
  input logic             nvz_we_o
);

  logic [WIDTH:0] plain_sum;
  logic           a_bcd, b_bcd, r_bcd;

  always_comb begin
    plain_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    a_bcd = 1'b1;
    b_bcd = 1'b1;
    r_bcd = 1'b1;
    for (int d = 0; d < NDIGITS; d++) begin
      if (a_i[d*4 +: 4] > 4'd9)   a_bcd = 1'b0;
      if (b_i[d*4 +: 4] > 4'd9)   b_bcd = 1'b0;
      if (res_o[d*4 +: 4] > 4'd9) r_bcd = 1'b0;
    end
  end

  always_comb begin
    if (!dec_i && !sub_i)
      AST_BIN_ADD_SUM: assert ({cout_o, res_o} == plain_sum) else $error("binary add sum"); // R1
    if (!dec_i && !sub_i && (a_i[WIDTH-1] == b_i[WIDTH-1]))
      AST_ADD_OVERFLOW: assert (v_o == (res_o[WIDTH-1] != a_i[WIDTH-1])) else $error("overflow"); // R3
    if (!dec_i)
      AST_ZERO_FLAG: assert (z_o == (res_o == '0) && n_o == res_o[WIDTH-1]) else $error("n/z"); // R4
    if (dec_i && a_bcd && b_bcd)
      AST_BCD_DIGITS: assert (r_bcd) else $error("non-decimal digit"); // R5
    if (dec_i)
      AST_DEC_NO_NVZ: assert (!nvz_we_o) else $error("nvz enable in decimal"); // R7
    if (!op_valid_i)
      AST_IDLE_NO_WRITE: assert (!carry_we_o && !nvz_we_o) else $error("enable while idle"); // R9
  end

endmodule

bind bcd_addsub bcd_addsub_chk #(.NDIGITS(NDIGITS)) u_chk (
  .op_valid_i (op_valid_i),
  .sub_i      (sub_i),
  .dec_i      (dec_i),
  .cin_i      (cin_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .res_o      (res_o),
  .cout_o     (cout_o),
  .carry_we_o (carry_we_o),
  .n_o        (n_o),
  .v_o        (v_o),
  .z_o        (z_o),
  .nvz_we_o   (nvz_we_o)
);

// File: tb/sim_bcd_addsub.sv
`timescale 1ns/100ps
module sim_bcd_addsub;

  logic       clk;
  logic       op_valid, sub, dec, cin;
  logic [7:0] a, b;
  logic [7:0] res;
  logic       cout, carry_we, n, v, z, nvz_we;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bcd_addsub u0 (
    .op_valid_i (op_valid), .sub_i (sub), .dec_i (dec), .cin_i (cin),
    .a_i (a), .b_i (b), .res_o (res), .cout_o (cout),
    .carry_we_o (carry_we), .n_o (n), .v_o (v), .z_o (z), .nvz_we_o (nvz_we)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {sub, dec, cin, a, b, expected result, expected carry}
  localparam int NV = 14;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,8'hFF,8'h01,8'h00,1'b1},  // R1 wrap
    {1'b0,1'b0,1'b1,8'h7F,8'h00,8'h80,1'b0},  // R1 carry-in
    {1'b1,1'b0,1'b1,8'h00,8'h01,8'hFF,1'b0},  // R2 borrow
    {1'b1,1'b0,1'b1,8'h50,8'h50,8'h00,1'b1},  // R2 equal
    {1'b1,1'b0,1'b0,8'h50,8'h50,8'hFF,1'b0},  // R2 pending borrow
    {1'b0,1'b1,1'b1,8'h99,8'h99,8'h99,1'b1},  // R5 top
    {1'b0,1'b1,1'b0,8'h45,8'h55,8'h00,1'b1},  // R5 to hundred
    {1'b0,1'b1,1'b0,8'h09,8'h01,8'h10,1'b0},  // R5 digit carry
    {1'b1,1'b1,1'b1,8'h00,8'h01,8'h99,1'b0},  // R6 wrap
    {1'b1,1'b1,1'b1,8'h10,8'h01,8'h09,1'b1},  // R6 digit borrow
    {1'b1,1'b1,1'b0,8'h50,8'h50,8'h99,1'b0},  // R6 pending borrow
    {1'b0,1'b1,1'b0,8'h0A,8'h00,8'h10,1'b0},  // R10
    {1'b0,1'b1,1'b0,8'h0F,8'h0F,8'h14,1'b0},  // R10
    {1'b0,1'b1,1'b0,8'hA0,8'h00,8'h00,1'b1}   // R10
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit vld, input bit s, input bit d, input bit c,
                       input int av, input int bv);
    op_valid = vld; sub = s; dec = d; cin = c;
    a = 8'(av); b = 8'(bv);
    #0.5;
  endtask

  function automatic int to_bcd(input int x);
    return ((x / 10) << 4) | (x % 10);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    op_valid = 0; sub = 0; dec = 0; cin = 0; a = '0; b = '0;
    #0.3;

    // idle state before any operation: no flag writes (R9)
    drive(0, 0, 0, 0, 0, 0);
    chk(!carry_we && !nvz_we, "R9 idle start", {carry_we, nvz_we}, 0);
    #0.5;

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [27:0] e;
      e = VEC[i];
      drive(1, e[27], e[26], e[25], int'(e[24:17]), int'(e[16:9]));
      chk({res, cout} == e[8:0], $sformatf("R1/R2/R5/R6/R10 vec %0d", i),
          int'({res, cout}), int'(e[8:0]));
      #0.5;
    end

    // exhaustive binary: R1 R2 R3 R4 R8
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 2; c++)
        for (int ai = 0; ai < 256; ai++)
          for (int bi = 0; bi < 256; bi++) begin
            int full, er, ec, sa, sb, sv, ev;
            full = s ? (ai + (255 - bi) + c) : (ai + bi + c);
            er = full & 255;
            ec = (full >> 8) & 1;
            sa = (ai >= 128) ? ai - 256 : ai;
            sb = (bi >= 128) ? bi - 256 : bi;
            sv = s ? (sa - sb - (1 - c)) : (sa + sb + c);
            ev = (sv > 127 || sv < -128) ? 1 : 0;
            drive(1, s[0], 0, c[0], ai, bi);
            chk(int'(res) == er && int'(cout) == ec, s ? "R2 binary sub" : "R1 binary add",
                int'({cout, res}), (ec << 8) | er);
            chk(int'(v) == ev, "R3 overflow", int'(v), ev);
            chk(n == er[7] && z == (er == 0), "R4 n/z", int'({n, z}),
                int'({er[7], er == 0}));
            chk(carry_we && nvz_we, "R8 binary enables", int'({carry_we, nvz_we}), 3);
            #0.5;
          end

    // all BCD pairs: R5 R6 R7
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 2; c++)
        for (int x = 0; x < 100; x++)
          for (int y = 0; y < 100; y++) begin
            int val, ec;
            if (s == 0) begin
              val = x + y + c;
              ec  = (val >= 100) ? 1 : 0;
              val = val % 100;
            end else begin
              val = x - y - (1 - c);
              ec  = (val < 0) ? 0 : 1;
              if (val < 0) val = val + 100;
            end
            drive(1, s[0], 1, c[0], to_bcd(x), to_bcd(y));
            chk(int'(res) == to_bcd(val) && int'(cout) == ec,
                s ? "R6 decimal sub" : "R5 decimal add",
                int'({cout, res}), (ec << 8) | to_bcd(val));
            chk(carry_we && !nvz_we, "R7 decimal enables", int'({carry_we, nvz_we}), 2);
            #0.5;
          end

    // strobe low in both modes (R9)
    drive(0, 0, 0, 1, 8'h12, 8'h34);
    chk(!carry_we && !nvz_we, "R9 idle binary", int'({carry_we, nvz_we}), 0);
    #0.5;
    drive(0, 1, 1, 1, 8'h42, 8'h17);
    chk(!carry_we && !nvz_we, "R9 idle decimal", int'({carry_we, nvz_we}), 0);
    #0.5;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule